// File: doc/BRIEF.md
# PCI configuration header register file

This block stores the 64-byte type-0 configuration header of a single PCI function and serves configuration reads and writes of 1, 2 or 4 bytes at a byte offset. The access arrives as a single-cycle request (enable, write flag, offset, size, write data). The block answers on the next clock edge with registered read data and a one-cycle error pulse for any access it refuses.

Identification and type fields come from parameters at reset. Software may change only a small set of fields, and which ones depends on the access width. The six base address registers take part in the usual sizing handshake: an all-ones write makes the register read back its size mask, and the low type bits stay untouched. The expansion ROM base register has its own probe value. Everything beyond the header itself is left to the surrounding logic: the bus protocol, device selection and capability lists.

Top module: `cfg_hdr_regfile`

## Requirements
- R1: After reset the header reads as zero except for these little-endian fields, which hold their parameter values: vendor ID (bytes 0-1), device ID (2-3), revision (8), programming interface (9), subclass (0x0A), class (0x0B), header type (0x0E), interrupt pin (0x3D) and the low 4 type bits of each base register at 0x10, 0x14, 0x18, 0x1C, 0x20 and 0x24. After reset acc_rdata is 0 and acc_err is low.
- R2: A read of size 1, 2 or 4 at an offset aligned to its size returns the bytes at offset, offset+1, ... in little-endian order, zero-extended to 32 bits. The data appears on acc_rdata after the next rising clock edge and stays there until the next legal read. A read never changes the storage.
- R3: An access of size 3, size 0 or size 5 to 7, or one whose offset is not a multiple of its size, raises acc_err for exactly the cycle after the request and changes neither storage nor acc_rdata. acc_err stays low in any cycle that follows a cycle without a request.
- R4: A 1-byte write is accepted only at offsets 0x0C (cache line size) and 0x3C (interrupt line). At any other offset it is refused.
- R5: A 2-byte write is accepted only at offsets 0x04 (command), 0x06 (status) and 0x0C (cache line size plus latency timer). At any other offset it is refused.
- R6: A 4-byte write is accepted only at the base registers (0x10 to 0x24), at the expansion ROM base register (0x30) and at 0x04. A 4-byte write at 0x04 stores only bits 15:0 into the command field and leaves the status field at 0x06 unchanged.
- R7: A 4-byte write of 0xFFFFFFFF to base register n stores ~(BAR_SIZE[n]-1) with its read-only low bits replaced by the current type bits.
- R8: A base register whose bit 0 is 1 is an I/O register. Its bits 1:0 never change, and other writes store the data with those two bits masked off.
- R9: A base register whose bit 0 is 0 is a memory register. Its bits 3:0 never change under any write.
- R10: A 4-byte write of 0xFFFFFFFE to offset 0x30 makes that register read 0xFFFFFFFF. Any other 4-byte value written there is stored unchanged.
- R11: A refused write leaves all 64 bytes and acc_rdata unchanged and raises acc_err for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access request, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_off | input | 6 | Byte offset inside the header |
| acc_size | input | 3 | Access size in bytes |
| acc_wdata | input | 32 | Write data, byte at the offset in bits 7:0 |
| acc_rdata | output | 32 | Registered read data |
| acc_err | output | 1 | One-cycle pulse for a refused access |

## Verification
The bench gives the six base registers a mixed set of parameters: two I/O registers of 256 and 32 bytes, a prefetchable memory register of 4 KiB (type 0x8), a 16-byte memory register and two registers of size zero. With this set, one run probes both type-bit masks, the smallest legal memory size and the case where a probe returns only the type bits. The identification parameters are distinct non-zero bytes, so a byte-lane or endianness slip shows up in the reset image. A behavioural byte-array model predicts acc_rdata and acc_err on every clock, including the cycles between accesses.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

   localparam int CFG_BYTES = 64;
   localparam int OFF_W     = $clog2(CFG_BYTES);
   localparam int IMG_W     = CFG_BYTES * 8;
   localparam int NUM_BAR   = 6;

   // Header offsets the decode depends on.
   localparam int OFF_VENDOR  = 'h00;
   localparam int OFF_DEVICE  = 'h02;
   localparam int OFF_CMD     = 'h04;
   localparam int OFF_STAT    = 'h06;
   localparam int OFF_REV     = 'h08;
   localparam int OFF_PROGIF  = 'h09;
   localparam int OFF_SUBCLS  = 'h0A;
   localparam int OFF_CLASS   = 'h0B;
   localparam int OFF_CLSZ    = 'h0C;
   localparam int OFF_HDRTYPE = 'h0E;
   localparam int OFF_BAR0    = 'h10;
   localparam int OFF_BARLAST = OFF_BAR0 + 4 * (NUM_BAR - 1);
   localparam int OFF_ROM     = 'h30;
   localparam int OFF_INTLINE = 'h3C;
   localparam int OFF_INTPIN  = 'h3D;

   localparam logic [31:0] ROM_PROBE = 32'hFFFF_FFFE;

   typedef enum logic [2:0] {
      WK_NONE,
      WK_PLAIN,
      WK_CMD32,
      WK_BAR,
      WK_ROM
   } wr_kind_e;

endpackage

// File: rtl/cfg_acc_check.sv
module cfg_acc_check
   import cfg_hdr_pkg::*;
(
   input  logic             acc_en,
   input  logic             acc_wr,
   input  logic [OFF_W-1:0] acc_off,
   input  logic [2:0]       acc_size,
   output logic             rd_ok,
   output logic             wr_ok,
   output logic             bad,
   output wr_kind_e         kind,
   output logic [2:0]       bar_idx
);

   logic             size_legal;
   logic             aligned;
   logic             shape_ok;
   logic [OFF_W-1:0] bar_rel;

   assign size_legal = (acc_size == 3'd1) || (acc_size == 3'd2) || (acc_size == 3'd4);

   always_comb begin
      case (acc_size)
         3'd2:    aligned = (acc_off[0] == 1'b0);
         3'd4:    aligned = (acc_off[1:0] == 2'b00);
         default: aligned = 1'b1;
      endcase
   end

   assign shape_ok = size_legal && aligned;

   // Write permission depends on both the width and the target field.
   always_comb begin
      kind = WK_NONE;
      case (acc_size)
         3'd1: begin
            if (acc_off == OFF_W'(OFF_CLSZ) || acc_off == OFF_W'(OFF_INTLINE))
               kind = WK_PLAIN;
         end
         3'd2: begin
            if (acc_off == OFF_W'(OFF_CMD) || acc_off == OFF_W'(OFF_STAT) ||
                acc_off == OFF_W'(OFF_CLSZ))
               kind = WK_PLAIN;
         end
         3'd4: begin
            if (acc_off >= OFF_W'(OFF_BAR0) && acc_off <= OFF_W'(OFF_BARLAST))
               kind = WK_BAR;
            else if (acc_off == OFF_W'(OFF_ROM))
               kind = WK_ROM;
            else if (acc_off == OFF_W'(OFF_CMD))
               kind = WK_CMD32;
         end
         default: kind = WK_NONE;
      endcase
   end

   assign bar_rel = acc_off - OFF_W'(OFF_BAR0);
   assign bar_idx = bar_rel[4:2];

   assign rd_ok = acc_en && !acc_wr && shape_ok;
   assign wr_ok = acc_en &&  acc_wr && shape_ok && (kind != WK_NONE);
   assign bad   = acc_en && !rd_ok && !wr_ok;

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
   import cfg_hdr_pkg::*;
(
   input  logic [IMG_W-1:0] img,
   input  logic [OFF_W-1:0] off,
   input  logic [2:0]       size,
   output logic [31:0]      raw_word,
   output logic [31:0]      sized_word
);

   for (genvar k = 0; k < 4; k++) begin : g_lane
      logic [OFF_W-1:0] idx;
      assign idx = off + OFF_W'(k);
      assign raw_word[k*8 +: 8] = img[{idx, 3'b000} +: 8];
   end

   always_comb begin
      case (size)
         3'd1:    sized_word = {24'h0, raw_word[7:0]};
         3'd2:    sized_word = {16'h0, raw_word[15:0]};
         default: sized_word = raw_word;
      endcase
   end

endmodule

// File: rtl/cfg_bar_calc.sv
module cfg_bar_calc
   import cfg_hdr_pkg::*;
#(
   parameter logic [NUM_BAR*32-1:0] BAR_SIZE = '0
)(
   input  logic [2:0]  bar_idx,
   input  logic [31:0] old_word,
   input  logic [31:0] wdata,
   output logic [31:0] new_word
);

   logic [31:0] keep;
   logic [31:0] kept_bits;
   logic [31:0] user_bits;
   logic        probe;
   logic [31:0] size_mask;
   logic [31:0] mask_tab [NUM_BAR];

   // I/O registers protect two low bits, memory registers four.
   assign keep      = old_word[0] ? 32'h0000_0003 : 32'h0000_000F;
   assign kept_bits = old_word & keep;
   assign user_bits = wdata & ~keep;
   assign probe     = &wdata;

   for (genvar g = 0; g < NUM_BAR; g++) begin : g_bar
      localparam logic [31:0] SZ      = BAR_SIZE[g*32 +: 32];
      localparam logic [31:0] SZ_MASK = ~(SZ - 32'd1);
      assign mask_tab[g] = SZ_MASK;
   end

   always_comb begin
      size_mask = mask_tab[0];
      for (int i = 1; i < NUM_BAR; i++) begin
         if (bar_idx == 3'(i)) size_mask = mask_tab[i];
      end
   end

   assign new_word = probe ? ((size_mask & ~keep) | kept_bits)
                           : (user_bits | kept_bits);

endmodule

// File: rtl/cfg_byte_store.sv
module cfg_byte_store
   import cfg_hdr_pkg::*;
#(
   parameter logic [IMG_W-1:0] INIT_IMG = '0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [OFF_W-1:0] wr_off,
   input  logic [3:0]       wr_be,
   input  logic [31:0]      wr_word,
   output logic [IMG_W-1:0] img
);

   for (genvar b = 0; b < CFG_BYTES; b++) begin : g_byte
      logic [OFF_W-1:0] rel;
      logic             hit;
      logic [7:0]       q;

      assign rel = OFF_W'(b) - wr_off;
      assign hit = wr_en && (rel < OFF_W'(4)) && wr_be[rel[1:0]];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= INIT_IMG[b*8 +: 8];
         end else if (hit) begin
            q <= wr_word[{rel[1:0], 3'b000} +: 8];
         end
      end

      assign img[b*8 +: 8] = q;
   end

endmodule

// File: rtl/cfg_hdr_regfile.sv
module cfg_hdr_regfile
   import cfg_hdr_pkg::*;
#(
   parameter logic [15:0]           VENDOR_ID = 16'h1F00,
   parameter logic [15:0]           DEVICE_ID = 16'h0001,
   parameter logic [7:0]            REV_ID    = 8'h00,
   parameter logic [7:0]            PROG_IF   = 8'h00,
   parameter logic [7:0]            SUB_CLASS = 8'h00,
   parameter logic [7:0]            BASE_CLS  = 8'h00,
   parameter logic [7:0]            HDR_TYPE  = 8'h00,
   parameter logic [7:0]            INT_PIN   = 8'h01,
   parameter logic [NUM_BAR*32-1:0] BAR_SIZE  = {{(NUM_BAR-1){32'h0}}, 32'h0000_1000},
   parameter logic [NUM_BAR*4-1:0]  BAR_TYPE  = '0
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        acc_en,
   input  logic        acc_wr,
   input  logic [5:0]  acc_off,
   input  logic [2:0]  acc_size,
   input  logic [31:0] acc_wdata,
   output logic [31:0] acc_rdata,
   output logic        acc_err
);

   // Elaboration checks on the BAR parameters.
   for (genvar g = 0; g < NUM_BAR; g++) begin : g_param_chk
      localparam logic [31:0] SZ = BAR_SIZE[g*32 +: 32];
      localparam logic [3:0]  TY = BAR_TYPE[g*4 +: 4];
      if ((SZ & (SZ - 32'd1)) != 32'd0) begin : g_not_pow2
         $error("BAR size must be zero or a power of two");
      end
      if (SZ != 32'd0 && TY[0] && SZ < 32'd4) begin : g_io_small
         $error("I/O BAR size below 4 bytes");
      end
      if (SZ != 32'd0 && !TY[0] && SZ < 32'd16) begin : g_mem_small
         $error("memory BAR size below 16 bytes");
      end
   end
   if (OFF_W != 6) begin : g_width_chk
      $error("header offset width must be 6");
   end

   function automatic logic [IMG_W-1:0] build_image();
      logic [IMG_W-1:0] im;
      im = '0;
      im[OFF_VENDOR*8  +: 16] = VENDOR_ID;
      im[OFF_DEVICE*8  +: 16] = DEVICE_ID;
      im[OFF_REV*8     +: 8]  = REV_ID;
      im[OFF_PROGIF*8  +: 8]  = PROG_IF;
      im[OFF_SUBCLS*8  +: 8]  = SUB_CLASS;
      im[OFF_CLASS*8   +: 8]  = BASE_CLS;
      im[OFF_HDRTYPE*8 +: 8]  = HDR_TYPE;
      im[OFF_INTPIN*8  +: 8]  = INT_PIN;
      for (int i = 0; i < NUM_BAR; i++) begin
         im[(OFF_BAR0 + 4*i)*8 +: 4] = BAR_TYPE[i*4 +: 4];
      end
      return im;
   endfunction

   localparam logic [IMG_W-1:0] RESET_IMG = build_image();

   logic             rd_ok;
   logic             wr_ok;
   logic             bad;
   wr_kind_e         wr_kind;
   logic [2:0]       bar_idx;
   logic [31:0]      old_word;
   logic [31:0]      rd_sized;
   logic [31:0]      bar_word;
   logic [3:0]       st_be;
   logic [31:0]      st_word;
   logic [IMG_W-1:0] cfg_img;

   cfg_acc_check u_dec (
      .acc_en   (acc_en),
      .acc_wr   (acc_wr),
      .acc_off  (acc_off),
      .acc_size (acc_size),
      .rd_ok    (rd_ok),
      .wr_ok    (wr_ok),
      .bad      (bad),
      .kind     (wr_kind),
      .bar_idx  (bar_idx)
   );

   cfg_read_mux u_rd (
      .img        (cfg_img),
      .off        (acc_off),
      .size       (acc_size),
      .raw_word   (old_word),
      .sized_word (rd_sized)
   );

   cfg_bar_calc #(
      .BAR_SIZE (BAR_SIZE)
   ) u_bar (
      .bar_idx  (bar_idx),
      .old_word (old_word),
      .wdata    (acc_wdata),
      .new_word (bar_word)
   );

   always_comb begin
      st_be   = 4'b0000;
      st_word = acc_wdata;
      case (wr_kind)
         WK_PLAIN: st_be = (acc_size == 3'd1) ? 4'b0001 : 4'b0011;
         WK_CMD32: st_be = 4'b0011;
         WK_BAR: begin
            st_be   = 4'b1111;
            st_word = bar_word;
         end
         WK_ROM: begin
            st_be   = 4'b1111;
            st_word = (acc_wdata == ROM_PROBE) ? 32'hFFFF_FFFF : acc_wdata;
         end
         default: st_be = 4'b0000;
      endcase
   end

   cfg_byte_store #(
      .INIT_IMG (RESET_IMG)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_ok),
      .wr_off  (acc_off),
      .wr_be   (st_be),
      .wr_word (st_word),
      .img     (cfg_img)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_rdata <= 32'h0;
         acc_err   <= 1'b0;
      end else begin
         if (rd_ok) acc_rdata <= rd_sized;
         acc_err <= bad;
      end
   end

endmodule

// File: rtl/cfg_hdr_regfile_chk.sv
module cfg_hdr_regfile_chk
   import cfg_hdr_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             acc_en,
   input logic             acc_wr,
   input logic [5:0]       acc_off,
   input logic [2:0]       acc_size,
   input logic [31:0]      acc_wdata,
   input logic [31:0]      acc_rdata,
   input logic             acc_err,
   input logic [IMG_W-1:0] cfg_img
);

   // R1: identification bytes are never written
   p_id_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      acc_en |=> $stable(cfg_img[31:0]));

   // R2: reads do not disturb storage
   p_read_pure_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !acc_wr) |=> $stable(cfg_img));

   // R3: no error without a request
   p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_en |=> !acc_err);

   // R3: three-byte access always refused
   p_three_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && acc_size == 3'd3) |=> (acc_err && $stable(cfg_img)));

   // R4: single-byte write outside the two writable bytes is refused
   p_byte_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && acc_wr && acc_size == 3'd1 &&
       acc_off != 6'h0C && acc_off != 6'h3C) |=> acc_err);

   // R6: a 4-byte write at the command offset leaves status alone
   p_cmd32_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && acc_wr && acc_size == 3'd4 && acc_off == 6'h04)
      |=> $stable(cfg_img[OFF_STAT*8 +: 16]));

   // R10: ROM probe value reads back as all ones
   p_rom_probe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && acc_wr && acc_size == 3'd4 && acc_off == 6'h30 &&
       acc_wdata == ROM_PROBE) |=> (cfg_img[OFF_ROM*8 +: 32] == 32'hFFFF_FFFF));

   // R11: a refused write changes nothing
   p_reject_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && acc_wr) |=> (!acc_err || ($stable(cfg_img) && $stable(acc_rdata))));

   for (genvar g = 0; g < NUM_BAR; g++) begin : g_bar_props
      localparam int LSB = (OFF_BAR0 + 4*g) * 8;
      // R8: the low two bits of every base register never move
      p_bar_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
         acc_en |=> $stable(cfg_img[LSB +: 2]));
      // R9: memory registers also hold bits 3:2
      p_mem_type_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_en && !cfg_img[LSB]) |=> $stable(cfg_img[LSB+2 +: 2]));
   end

endmodule

bind cfg_hdr_regfile cfg_hdr_regfile_chk u_props (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_en    (acc_en),
   .acc_wr    (acc_wr),
   .acc_off   (acc_off),
   .acc_size  (acc_size),
   .acc_wdata (acc_wdata),
   .acc_rdata (acc_rdata),
   .acc_err   (acc_err),
   .cfg_img   (cfg_img)
);

// File: tb/cfg_hdr_regfile_tb_top.sv
module cfg_hdr_regfile_tb_top;

   localparam logic [15:0] T_VID  = 16'hC0DE;
   localparam logic [15:0] T_DID  = 16'h7A31;
   localparam logic [7:0]  T_REV  = 8'h05;
   localparam logic [7:0]  T_PIF  = 8'h11;
   localparam logic [7:0]  T_SUB  = 8'h80;
   localparam logic [7:0]  T_CLS  = 8'h02;
   localparam logic [7:0]  T_HDR  = 8'h40;
   localparam logic [7:0]  T_IPIN = 8'h01;
   // BAR5 .. BAR0
   localparam logic [191:0] T_BSZ = {32'h0, 32'h20, 32'h0, 32'h10, 32'h1000, 32'h100};
   localparam logic [23:0]  T_BTY = {4'h0, 4'h1, 4'h0, 4'h0, 4'h8, 4'h1};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_en = 1'b0;
   logic        acc_wr = 1'b0;
   logic [5:0]  acc_off = '0;
   logic [2:0]  acc_size = '0;
   logic [31:0] acc_wdata = '0;
   logic [31:0] acc_rdata;
   logic        acc_err;

   always #4 clk = ~clk;

   cfg_hdr_regfile #(
      .VENDOR_ID (T_VID), .DEVICE_ID (T_DID), .REV_ID (T_REV), .PROG_IF (T_PIF),
      .SUB_CLASS (T_SUB), .BASE_CLS (T_CLS), .HDR_TYPE (T_HDR), .INT_PIN (T_IPIN),
      .BAR_SIZE (T_BSZ), .BAR_TYPE (T_BTY)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .acc_en (acc_en), .acc_wr (acc_wr),
      .acc_off (acc_off), .acc_size (acc_size), .acc_wdata (acc_wdata),
      .acc_rdata (acc_rdata), .acc_err (acc_err)
   );

   logic [7:0]  mdl [64];
   logic        nxt_err = 1'b0;
   logic [31:0] nxt_rd = '0;
   logic        mon_on = 1'b0;
   string       cur_tag = "R1";
   int          n_chk = 0;
   int          n_bad = 0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic void mdl_init();
      for (int i = 0; i < 64; i++) mdl[i] = 8'h00;
      mdl[0] = T_VID[7:0];  mdl[1] = T_VID[15:8];
      mdl[2] = T_DID[7:0];  mdl[3] = T_DID[15:8];
      mdl[8] = T_REV; mdl[9] = T_PIF; mdl[10] = T_SUB; mdl[11] = T_CLS;
      mdl[14] = T_HDR; mdl[61] = T_IPIN;
      for (int b = 0; b < 6; b++) mdl[16 + 4*b] = {4'h0, T_BTY[b*4 +: 4]};
   endfunction

   function automatic logic [31:0] mdl_word(int off);
      return {mdl[(off+3)%64], mdl[(off+2)%64], mdl[(off+1)%64], mdl[off]};
   endfunction

   function automatic bit shape_ok(int sz, int off);
      return (sz == 1) || (sz == 2 && off % 2 == 0) || (sz == 4 && off % 4 == 0);
   endfunction

   function automatic bit wr_allowed(int sz, int off);
      case (sz)
         1: return off == 12 || off == 60;
         2: return off == 4 || off == 6 || off == 12;
         4: return (off >= 16 && off <= 36) || off == 48 || off == 4;
         default: return 1'b0;
      endcase
   endfunction

   function automatic void mdl_write(int sz, int off, logic [31:0] d);
      logic [31:0] old, keep, nw, bsz;
      if (sz == 1) begin
         mdl[off] = d[7:0];
      end else if (sz == 2 || (sz == 4 && off == 4)) begin
         mdl[off] = d[7:0]; mdl[off+1] = d[15:8];
      end else begin
         old = mdl_word(off);
         if (off == 48) begin
            nw = (d == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : d;
         end else begin
            bsz  = T_BSZ[((off - 16) / 4) * 32 +: 32];
            keep = old[0] ? 32'h3 : 32'hF;
            if (d == 32'hFFFF_FFFF) nw = (~(bsz - 32'd1) & ~keep) | (old & keep);
            else                    nw = (d & ~keep) | (old & keep);
         end
         for (int k = 0; k < 4; k++) mdl[off+k] = nw[k*8 +: 8];
      end
   endfunction

   // Compare outputs with the model after every rising edge.
   always @(posedge clk) begin
      if (mon_on) begin
         #2;
         chk({cur_tag, " acc_err"}, {31'b0, acc_err}, {31'b0, nxt_err});
         chk({cur_tag, " acc_rdata"}, acc_rdata, nxt_rd);
      end
   end

   task automatic access(bit wr, int off, int sz, logic [31:0] d, string tag);
      bit legal;
      logic [31:0] w;
      @(negedge clk);
      acc_en = 1'b1; acc_wr = wr; acc_off = off[5:0];
      acc_size = sz[2:0]; acc_wdata = d;
      legal = shape_ok(sz, off) && (!wr || wr_allowed(sz, off));
      nxt_err = !legal;
      if (legal && !wr) begin
         w = mdl_word(off);
         if (sz == 1) w = {24'h0, w[7:0]};
         else if (sz == 2) w = {16'h0, w[15:0]};
         nxt_rd = w;
      end
      if (legal && wr) mdl_write(sz, off, d);
      cur_tag = tag;
      @(negedge clk);
      acc_en = 1'b0;
      nxt_err = 1'b0;
      cur_tag = {tag, " idle R3"};
   endtask

   task automatic rd(int off, int sz, string tag);
      access(1'b0, off, sz, 32'h0, tag);
   endtask

   task automatic wr(int off, int sz, logic [31:0] d, string tag);
      access(1'b1, off, sz, d, tag);
   endtask

   task automatic dump(string tag);
      for (int o = 0; o < 64; o += 4) rd(o, 4, tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      mon_on = 1'b0;
      rst_n = 1'b0;
      acc_en = 1'b0;
      repeat (3) @(negedge clk);
      mdl_init();
      nxt_rd = '0;
      nxt_err = 1'b0;
      cur_tag = "R1 reset outputs";
      rst_n = 1'b1;
      mon_on = 1'b1;
   endtask

   initial begin
      #(8 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      mdl_init();
      do_reset();
      // R1: reset image
      rd(0, 2, "R1 vendor");
      rd(2, 2, "R1 device");
      rd(8, 4, "R1 class word");
      rd(14, 1, "R1 header type");
      rd(61, 1, "R1 int pin");
      rd(16, 4, "R1 bar0 type");
      rd(20, 4, "R1 bar1 type");
      dump("R1 dump");
      // R2: reads of each width
      rd(1, 1, "R2 byte read");
      rd(10, 2, "R2 half read");
      rd(60, 4, "R2 word read");
      // R3: illegal shapes
      access(1'b0, 0, 3, 32'h0, "R3 size3 read");
      access(1'b1, 12, 3, 32'h12345678, "R3 size3 write");
      access(1'b0, 0, 0, 32'h0, "R3 size0");
      access(1'b0, 8, 5, 32'h0, "R3 size5");
      access(1'b0, 8, 7, 32'h0, "R3 size7");
      rd(1, 2, "R3 misaligned half");
      rd(2, 4, "R3 misaligned word");
      wr(5, 2, 32'h0000_BEEF, "R3 misaligned write");
      wr(18, 4, 32'hFFFF_FFFF, "R3 misaligned bar write");
      // R4: byte writes
      wr(60, 1, 32'h0000_000B, "R4 int line write");
      rd(60, 1, "R4 int line read");
      wr(12, 1, 32'h0000_0010, "R4 cache line write");
      rd(12, 4, "R4 cache line read");
      wr(0, 1, 32'h0000_00AA, "R4 vendor byte refused");
      wr(61, 1, 32'h0000_00AA, "R4 int pin refused");
      wr(4, 1, 32'h0000_00AA, "R4 command byte refused");
      wr(16, 1, 32'h0000_00AA, "R4 bar byte refused");
      // R5: half-word writes
      wr(4, 2, 32'h0000_0147, "R5 command write");
      wr(6, 2, 32'h0000_8000, "R5 status write");
      rd(4, 4, "R5 cmd/status read");
      wr(12, 2, 32'h0000_4020, "R5 cache/latency write");
      rd(12, 4, "R5 cache/latency read");
      wr(0, 2, 32'h0000_5555, "R5 vendor refused");
      wr(60, 2, 32'h0000_5555, "R5 int half refused");
      wr(16, 2, 32'h0000_5555, "R5 bar half refused");
      // R6: word writes
      wr(4, 4, 32'hDEAD_0006, "R6 command word");
      rd(4, 4, "R6 status kept");
      wr(0, 4, 32'h1111_2222, "R6 id word refused");
      wr(8, 4, 32'h1111_2222, "R6 class word refused");
      wr(40, 4, 32'h1111_2222, "R6 cardbus refused");
      wr(60, 4, 32'h1111_2222, "R6 int word refused");
      // R7: sizing probes on every base register
      for (int b = 0; b < 6; b++) begin
         wr(16 + 4*b, 4, 32'hFFFF_FFFF, "R7 probe");
         rd(16 + 4*b, 4, "R7 probe readback");
      end
      // R8: I/O registers
      wr(16, 4, 32'h0000_C0FE, "R8 io bar0 write");
      rd(16, 4, "R8 io bar0 read");
      wr(32, 4, 32'h0000_0102, "R8 io bar4 write");
      rd(32, 4, "R8 io bar4 read");
      // R9: memory registers
      wr(20, 4, 32'h1234_5677, "R9 mem bar1 write");
      rd(20, 4, "R9 mem bar1 read");
      wr(24, 4, 32'hFFFF_FFF5, "R9 mem bar2 write");
      rd(24, 4, "R9 mem bar2 read");
      // R10: expansion ROM register
      wr(48, 4, 32'hFFFF_FFFE, "R10 rom probe");
      rd(48, 4, "R10 rom probe read");
      wr(48, 4, 32'hABCD_0001, "R10 rom plain");
      rd(48, 4, "R10 rom plain read");
      wr(48, 4, 32'hFFFF_FFFF, "R10 rom all ones");
      rd(48, 4, "R10 rom all ones read");
      // R11: refused writes leave state and read data alone
      rd(8, 4, "R11 set read data");
      wr(44, 4, 32'hCAFE_F00D, "R11 subsystem refused");
      wr(62, 2, 32'h0000_FFFF, "R11 grant/latency refused");
      wr(8, 1, 32'h0000_00FF, "R11 revision refused");
      dump("R11 dump");
      // R1: reset again after traffic
      do_reset();
      dump("R1 second reset");
      repeat (2) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule